// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns a single burst request into the full list of per-beat addresses. The requester sends the address only once. A request carries a start address, a beat count, a transfer size and a burst mode. It is accepted through a valid/ready handshake. The block then presents one address per beat on its own valid/ready beat port, and it flags the final beat.

Three stepping modes are supported:

- The fixed mode repeats the start address on every beat.
- The incrementing mode adds the beat size in bytes after each beat.
- The wrapping mode adds the beat size in the same way, but folds back to the bottom of an aligned window. The window is beats times size bytes. This lets a critical word in the middle of a line go out first, and the rest of the line follows without a new address.

Only one burst is in flight at a time. The request port stays closed until the final beat has been taken.

Top module: `burst_addr_gen`

## Requirements
- R1: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high. In the next cycle `beat_valid_o` is high and `beat_addr_o` equals the start address.
- R2: Burst mode code 0 (fixed) gives the start address on every beat.
- R3: Burst mode code 1 (incrementing) adds 2^`req_size_i` bytes to the address after each transferred beat. The size code ranges from 0 to 3, for 1 to 8 bytes. The addition wraps modulo 2^ADDR_W.
- R4: Burst mode code 2 (wrapping) applies when the beat count is 2, 4, 8 or 16. The address steps as in R3 but stays inside a window of (beats << size) bytes. The window's base is the start address with its low log2(beats<<size) bits cleared. The step after the window's top byte lands on the base.
- R5: Burst mode code 2 with any other beat count, and the reserved mode code 3, both step exactly as in R3.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, `beat_addr_o` and `beat_last_o` are held in the next cycle, and `beat_valid_o` stays high.
- R7: `req_len_i` holds the beat count minus one. A burst delivers exactly that many beats plus one. `beat_last_o` is high on the final beat only.
- R8: While a burst is in progress, `req_ready_o` is low and requests have no effect. In the cycle after the final beat transfers, `req_ready_o` is high and `beat_valid_o` is low.
- R9: After reset, `req_ready_o` is high and `beat_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, can take a request |
| req_addr_i | input | ADDR_W | Start address, aligned to the beat size |
| req_len_i | input | LEN_W | Beat count minus one |
| req_size_i | input | 2 | log2 of bytes per beat |
| req_burst_i | input | 2 | Mode: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_valid_o | output | 1 | Beat address present |
| beat_ready_i | input | 1 | Consumer takes the beat |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| beat_last_o | output | 1 | Current beat is the final one |

## Verification
The first beat address is due one cycle after the edge that takes the request. Each following address is due one cycle after the edge where the previous beat transferred. The return to idle is due one cycle after the final transfer.

The bench drives every input just after a falling edge and samples every output just before the next rising edge. Each expected value therefore lines up with exactly one register stage.

Under back-pressure, the bench compares the held address and last flag across each stalled cycle. It also injects a stray request during a busy cycle and confirms that the later beats are unaffected.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_mode_e;

  localparam int unsigned MAX_WRAP_LOG2 = 4;  // wrap lengths 2..16 beats

endpackage

// File: rtl/burst_wrap_mask.sv
module burst_wrap_mask
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] mask_o,
  output logic              wrap_ok_o
);

  localparam int unsigned N_LEGAL = MAX_WRAP_LOG2;

  logic [N_LEGAL-1:0] hit;

  // one comparator per legal wrap length (2^k beats)
  for (genvar k = 1; k <= N_LEGAL; k++) begin : g_len
    if (k <= LEN_W) begin : g_fit
      assign hit[k-1] = (len_i == LEN_W'((1 << k) - 1));
    end else begin : g_nofit
      assign hit[k-1] = 1'b0;
    end
  end

  assign wrap_ok_o = |hit;

  always_comb begin
    mask_o = ((ADDR_W'(len_i) + ADDR_W'(1)) << size_i) - ADDR_W'(1);
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  burst_mode_e       mode_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] next_o
);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    inc = ADDR_W'(1) << size_i;
    sum = addr_i + inc;
    unique case (mode_i)
      BURST_FIXED: next_o = addr_i;
      BURST_WRAP:  next_o = (addr_i & ~mask_i) | (sum & mask_i);
      default:     next_o = sum;
    endcase
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_ready_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             step_o
);

  logic [LEN_W-1:0] left_q;
  logic             busy_q;
  logic             fire;

  assign fire   = busy_q & beat_ready_i;
  assign last_o = busy_q & (left_q == '0);
  assign step_o = fire & ~last_o;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      left_q <= len_i;
    end else if (fire) begin
      if (last_o) busy_q <= 1'b0;
      else        left_q <= left_q - LEN_W'(1);
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_burst_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_last_o
);

  logic              busy;
  logic              step;
  logic              req_fire;
  logic              wrap_ok;
  logic [ADDR_W-1:0] mask_d;
  logic [ADDR_W-1:0] next_addr;
  burst_mode_e       mode_d;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mask_q;
  logic [1:0]        size_q;
  burst_mode_e       mode_q;

  assign req_ready_o = ~busy;
  assign req_fire    = req_valid_i & req_ready_o;

  burst_wrap_mask #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mask (
    .len_i     (req_len_i),
    .size_i    (req_size_i),
    .mask_o    (mask_d),
    .wrap_ok_o (wrap_ok)
  );

  // resolve the effective mode once, at accept time
  always_comb begin
    unique case (req_burst_i)
      2'd0:    mode_d = BURST_FIXED;
      2'd2:    mode_d = wrap_ok ? BURST_WRAP : BURST_INCR;
      default: mode_d = BURST_INCR;
    endcase
  end

  burst_beat_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_fire),
    .len_i        (req_len_i),
    .beat_ready_i (beat_ready_i),
    .busy_o       (busy),
    .last_o       (beat_last_o),
    .step_o       (step)
  );

  burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_i (addr_q),
    .size_i (size_q),
    .mode_i (mode_q),
    .mask_i (mask_q),
    .next_o (next_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mask_q <= '0;
      size_q <= '0;
      mode_q <= BURST_FIXED;
    end else if (req_fire) begin
      addr_q <= req_addr_i;
      mask_q <= mask_d;
      size_q <= req_size_i;
      mode_q <= mode_d;
    end else if (step) begin
      addr_q <= next_addr;
    end
  end

  assign beat_valid_o = busy;
  assign beat_addr_o  = addr_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic              beat_last_o,
  input logic [1:0]        mode_q
);

  p_first_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> beat_valid_o && beat_addr_o == $past(req_addr_i));

  p_fixed_same_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && !beat_last_o && mode_q == 2'd0
    |=> beat_addr_o == $past(beat_addr_o));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i
    |=> beat_valid_o && $stable(beat_addr_o) && $stable(beat_last_o));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_ready_i && beat_last_o |=> !beat_valid_o && req_ready_o);

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !req_ready_o);

  p_idle_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> req_ready_o);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_addr_o  (beat_addr_o),
  .beat_last_o  (beat_last_o),
  .mode_q       (mode_q)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned LEN_W  = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic [1:0]        req_size_i = '0;
  logic [1:0]        req_burst_i = '0;
  logic              beat_valid_o;
  logic              beat_ready_i = 1'b0;
  logic [ADDR_W-1:0] beat_addr_o;
  logic              beat_last_o;

  int n_run  = 0;
  int n_fail = 0;
  int bp_cnt = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .req_size_i, .req_burst_i, .beat_valid_o, .beat_ready_i, .beat_addr_o,
    .beat_last_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(int start, int idx, int len, int size, int bt);
    int step, bytes, base;
    step = idx << size;
    if (bt == 0) return start;
    if (bt == 2 && (len == 1 || len == 3 || len == 7 || len == 15)) begin
      bytes = (len + 1) << size;
      base  = start - (start % bytes);
      return base + ((start - base + step) % bytes);
    end
    return (start + step) % 65536;
  endfunction

  function automatic string tag(int bt, int len);
    if (bt == 0) return "R2";
    if (bt == 1) return "R3";
    if (bt == 2 && (len == 1 || len == 3 || len == 7 || len == 15)) return "R4";
    return "R5";
  endfunction

  task automatic run_burst(input int start, input int len, input int size,
                           input int bt, input bit bp);
    bit rdy;
    int held_a, held_l;
    @(negedge clk_i);
    check("R8 idle ready", int'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_addr_i  = ADDR_W'(start);
    req_len_i   = LEN_W'(len);
    req_size_i  = 2'(size);
    req_burst_i = 2'(bt);
    @(negedge clk_i);
    // stray request while busy must be ignored
    req_addr_i  = ADDR_W'(start ^ 16'h5550);
    req_len_i   = LEN_W'(len ^ 5);
    req_burst_i = 2'(bt ^ 1);
    check("R1 first valid", int'(beat_valid_o), 1);
    check("R1 first addr", int'(beat_addr_o), start);
    check("R8 busy not ready", int'(req_ready_o), 0);
    for (int i = 0; i <= len; i++) begin
      forever begin
        rdy = bp ? (bp_cnt % 3 != 1) : 1'b1;
        bp_cnt++;
        beat_ready_i = rdy;
        check("R7 beat valid", int'(beat_valid_o), 1);
        check({tag(bt, len), " beat addr"}, int'(beat_addr_o),
              exp_addr(start, i, len, size, bt));
        check("R7 last flag", int'(beat_last_o), int'(i == len));
        held_a = int'(beat_addr_o);
        held_l = int'(beat_last_o);
        @(negedge clk_i);
        req_valid_i = 1'b0;
        if (rdy) break;
        check("R6 held addr", int'(beat_addr_o), held_a);
        check("R6 held last", int'(beat_last_o), held_l);
      end
    end
    beat_ready_i = 1'b0;
    check("R8 done valid low", int'(beat_valid_o), 0);
    check("R8 done ready high", int'(req_ready_o), 1);
  endtask

  initial begin
    int starts[3];
    starts[0] = 16'h0100;
    starts[1] = 16'h1238;
    starts[2] = 16'hFFF8;
    repeat (3) @(negedge clk_i);
    check("R9 reset ready", int'(req_ready_o), 1);
    check("R9 reset valid", int'(beat_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 post-reset ready", int'(req_ready_o), 1);
    check("R9 post-reset valid", int'(beat_valid_o), 0);
    for (int bt = 0; bt < 4; bt++)
      for (int size = 0; size < 4; size++)
        for (int len = 0; len < 16; len++)
          for (int s = 0; s < 3; s++)
            run_burst(starts[s], len, size, bt, (s + len) % 2 == 1);
    // critical word in the middle of a line, with stalls
    run_burst(16'h010C, 3, 2, 2, 1'b1);
    run_burst(16'h0138, 15, 3, 2, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule